// File: doc/BRIEF.md
# Self-Routing Eight-Port Multistage Switch Fabric

This block moves fixed-size cells from eight input ports to eight output ports through three ranks of two-by-two switching elements. No scheduler or central controller is involved: every cell carries its own 3-bit destination port number, and each rank looks at one bit of that number to steer the cell up or down inside its element. The ranks are joined by perfect-shuffle wiring, so a lone cell always reaches the port it names.

Each port offers one cell per clock as a valid flag, a destination and a data word. All eight ports share one cell slot per clock. Each rank is registered, so a slot leaves the fabric exactly three clocks after it enters, and a new slot may enter every clock.

When two cells in one element ask for the same element output in the same slot, the cell on the element's upper input goes on. The other cell is discarded. Its original input port is reported on a blocked flag that appears in the same cycle as the outputs of that slot. Buffering, retry and multicast belong to the blocks around this one.

Top module: `banyan_fabric`

## Requirements
- R1: While reset is high, and in the first cycles after reset before any accepted cell can arrive, every `out_vld` bit and every `blocked` bit is 0.
- R2: A single valid cell entering at any input with any destination d appears on output d, with its data unchanged, exactly 3 clocks after the edge that accepts it. No `blocked` bit is set for it.
- R3: Whenever `out_vld[i]` is 1, `out_dst[i]` equals i.
- R4: Rank k (k = 1..3) steers on destination bit 3-k, so the most significant bit is used first. A bit value of 1 selects the element's lower output (odd line) and 0 selects the upper output (even line). Element j of each rank takes lines 2j (upper) and 2j+1 (lower). Line q of a rank is fed from line rotate-right(q) of the rank before it, and the rank-1 lines are fed from the input ports the same way. Destination 101 therefore goes lower, upper, lower.
- R5: When both inputs of an element carry valid cells that want the same output, the cell on the upper input passes and the other is dropped. The dropped cell's original input bit of `blocked` is 1 in the cycle its slot leaves the fabric.
- R6: For every slot, the number of `out_vld` bits plus the number of `blocked` bits equals the number of valid inputs in that slot. A delivered cell's input is never also flagged blocked.
- R7: An input whose valid bit is 0 has no effect: its destination and data reach no output and set no `blocked` bit.
- R8: Patterns whose paths share no element output deliver every cell with no `blocked` bit set. These include the identity mapping and every uniform cyclic shift of destinations.
- R9: Slots entering on consecutive clocks are handled independently, at a throughput of one slot per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 8 | Per-input cell valid |
| in_dst | input | 8x3 | Per-input destination port number |
| in_data | input | 8x16 | Per-input data word |
| out_vld | output | 8 | Per-output cell valid |
| out_dst | output | 8x3 | Destination field of the delivered cell |
| out_data | output | 8x16 | Data word of the delivered cell |
| blocked | output | 8 | Per-input flag: that input's cell in this slot was dropped |

## Verification
Two things can happen in the same cycle. One slot can deliver some cells while dropping others, and a rank can resolve a contention while the blocked flags carried from an earlier rank pass through it. Hot-spot slots, where all inputs aim at one port, and random full-load slots issued back to back provoke both at once. Each slot's outputs and blocked vector are then compared against a bench model. That model traces each cell's line number rank by rank with integer arithmetic and settles every contention by the upper-line rule.

// File: rtl/banyan_pkg.sv
package banyan_pkg;

    localparam int PORT_W = 3;
    localparam int NPORTS = 1 << PORT_W;
    localparam int NELEM  = NPORTS / 2;
    localparam int DATA_W = 16;
    localparam int LAT    = PORT_W;

    typedef struct packed {
        logic              vld;
        logic [PORT_W-1:0] dst;
        logic [PORT_W-1:0] src;
        logic [DATA_W-1:0] data;
    } cell_t;

    localparam cell_t CELL_EMPTY = '0;

    // Source line feeding line q after a perfect shuffle (rotate right by one).
    function automatic int unsigned shuffle_src(input int unsigned q);
        return ((q >> 1) | ((q & 1) << (PORT_W - 1))) & (NPORTS - 1);
    endfunction

endpackage

// File: rtl/banyan_element.sv
module banyan_element
    import banyan_pkg::*;
#(
    parameter int SEL = 0
) (
    input  cell_t             up_i,
    input  cell_t             lo_i,
    output cell_t             up_o,
    output cell_t             lo_o,
    output logic              drop_o,
    output logic [PORT_W-1:0] drop_src_o
);

    logic up_bit;
    logic lo_bit;

    always_comb begin
        up_bit = up_i.dst[SEL];
        lo_bit = lo_i.dst[SEL];
        up_o   = CELL_EMPTY;
        lo_o   = CELL_EMPTY;
        if (lo_i.vld) begin
            if (lo_bit) begin
                lo_o = lo_i;
            end else begin
                up_o = lo_i;
            end
        end
        // The upper input is placed last so that it overrides on contention.
        if (up_i.vld) begin
            if (up_bit) begin
                lo_o = up_i;
            end else begin
                up_o = up_i;
            end
        end
        drop_o     = up_i.vld && lo_i.vld && (up_bit == lo_bit);
        drop_src_o = lo_i.src;
    end

endmodule

// File: rtl/banyan_stage.sv
module banyan_stage
    import banyan_pkg::*;
#(
    parameter int STG = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  cell_t [NPORTS-1:0]     cell_i,
    input  logic  [NPORTS-1:0]     blk_i,
    output cell_t [NPORTS-1:0]     cell_q,
    output logic  [NPORTS-1:0]     blk_q
);

    localparam int SEL = PORT_W - 1 - STG;

    cell_t [NPORTS-1:0]           shuf;
    cell_t [NPORTS-1:0]           sw;
    logic  [NELEM-1:0]            drop;
    logic  [NELEM-1:0][PORT_W-1:0] drop_src;
    logic  [NPORTS-1:0]           blk_n;

    for (genvar q = 0; q < NPORTS; q++) begin : g_shuf
        assign shuf[q] = cell_i[shuffle_src(q)];
    end

    for (genvar e = 0; e < NELEM; e++) begin : g_elem
        banyan_element #(.SEL(SEL)) u_elem (
            .up_i       (shuf[2*e]),
            .lo_i       (shuf[2*e+1]),
            .up_o       (sw[2*e]),
            .lo_o       (sw[2*e+1]),
            .drop_o     (drop[e]),
            .drop_src_o (drop_src[e])
        );

        // R5: the upper contender is the one that appears on the contested line
        p_upper_wins_r5: assert property (@(posedge clk) disable iff (rst)
            (shuf[2*e].vld && shuf[2*e+1].vld &&
             (shuf[2*e].dst[SEL] == shuf[2*e+1].dst[SEL]))
            |=> (($past(shuf[2*e].dst[SEL]) ? cell_q[2*e+1].src : cell_q[2*e].src)
                 == $past(shuf[2*e].src))
                && blk_q[$past(shuf[2*e+1].src)]);
    end

    always_comb begin
        blk_n = blk_i;
        for (int e = 0; e < NELEM; e++) begin
            if (drop[e]) begin
                blk_n[drop_src[e]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_q <= '0;
            blk_q  <= '0;
        end else begin
            cell_q <= sw;
            blk_q  <= blk_n;
        end
    end

    // R5: a drop reported by an earlier rank is carried forward
    p_blk_keep_r5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((blk_q & $past(blk_i)) == $past(blk_i)));

    for (genvar k = 0; k < NPORTS; k++) begin : g_chk
        // R6: a cell still travelling is never flagged as dropped
        p_alive_not_blocked_r6: assert property (@(posedge clk) disable iff (rst)
            cell_q[k].vld |-> !blk_q[cell_q[k].src]);
    end

endmodule

// File: rtl/banyan_fabric.sv
module banyan_fabric
    import banyan_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NPORTS-1:0]              in_vld,
    input  logic [NPORTS-1:0][PORT_W-1:0]  in_dst,
    input  logic [NPORTS-1:0][DATA_W-1:0]  in_data,
    output logic [NPORTS-1:0]              out_vld,
    output logic [NPORTS-1:0][PORT_W-1:0]  out_dst,
    output logic [NPORTS-1:0][DATA_W-1:0]  out_data,
    output logic [NPORTS-1:0]              blocked
);

    cell_t [NPORTS-1:0] cells [LAT+1];
    logic  [NPORTS-1:0] blk   [LAT+1];

    for (genvar i = 0; i < NPORTS; i++) begin : g_inject
        assign cells[0][i] = '{vld:  in_vld[i],
                               dst:  in_dst[i],
                               src:  PORT_W'(i),
                               data: in_data[i]};
    end
    assign blk[0] = '0;

    for (genvar s = 0; s < LAT; s++) begin : g_rank
        banyan_stage #(.STG(s)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .cell_i (cells[s]),
            .blk_i  (blk[s]),
            .cell_q (cells[s+1]),
            .blk_q  (blk[s+1])
        );
    end

    for (genvar i = 0; i < NPORTS; i++) begin : g_out
        assign out_vld[i]  = cells[LAT][i].vld;
        assign out_dst[i]  = cells[LAT][i].dst;
        assign out_data[i] = cells[LAT][i].data;

        // R3: a delivered cell sits on the port it asked for
        p_dst_match_r3: assert property (@(posedge clk) disable iff (rst)
            out_vld[i] |-> (out_dst[i] == PORT_W'(i)));
    end
    assign blocked = blk[LAT];

    // Cycles since reset, saturating at the fabric latency; used by checks only.
    logic [7:0] age;
    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (age < 8'(LAT)) begin
            age <= age + 8'd1;
        end
    end

    // R1: reset leaves the fabric empty
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (out_vld == '0) && (blocked == '0));

    // R6: every valid input of a slot is either delivered or flagged
    p_conserve_r6: assert property (@(posedge clk) disable iff (rst)
        (age == 8'(LAT)) |->
            ($countones(out_vld) + $countones(blocked)) == $past($countones(in_vld), LAT));

endmodule

// File: tb/test_banyan_fabric.sv
`timescale 1ns/1ps
module test_banyan_fabric;
    import banyan_pkg::*;

    typedef struct packed {
        logic [NPORTS-1:0]             vld;
        logic [NPORTS-1:0]             blk;
        logic [NPORTS-1:0][DATA_W-1:0] data;
    } slot_t;

    logic                          clk = 1'b0;
    logic                          rst = 1'b1;
    logic [NPORTS-1:0]             in_vld = '0;
    logic [NPORTS-1:0][PORT_W-1:0] in_dst = '0;
    logic [NPORTS-1:0][DATA_W-1:0] in_data = '0;
    logic [NPORTS-1:0]             out_vld;
    logic [NPORTS-1:0][PORT_W-1:0] out_dst;
    logic [NPORTS-1:0][DATA_W-1:0] out_data;
    logic [NPORTS-1:0]             blocked;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    slot_t exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    banyan_fabric i_banyan_fabric (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_dst(in_dst), .in_data(in_data),
        .out_vld(out_vld), .out_dst(out_dst), .out_data(out_data), .blocked(blocked)
    );

    // Behavioural model: follows each cell's line number rank by rank.
    function automatic slot_t model(input logic [NPORTS-1:0] v,
                                    input logic [NPORTS-1:0][PORT_W-1:0] d,
                                    input logic [NPORTS-1:0][DATA_W-1:0] x);
        slot_t r;
        int line[NPORTS];
        int inl[NPORTS];
        int nl[NPORTS];
        bit alive[NPORTS];
        bit lose[NPORTS];
        r = '0;
        for (int s = 0; s < NPORTS; s++) begin
            alive[s] = v[s];
            line[s] = s;
        end
        for (int k = 1; k <= PORT_W; k++) begin
            for (int s = 0; s < NPORTS; s++) begin
                inl[s] = ((line[s] << 1) | (line[s] >> (PORT_W - 1))) & (NPORTS - 1);
                nl[s] = (inl[s] & (NPORTS - 2)) | ((int'(d[s]) >> (PORT_W - k)) & 1);
                lose[s] = 0;
            end
            for (int s = 0; s < NPORTS; s++)
                for (int t = 0; t < NPORTS; t++)
                    if (alive[s] && alive[t] && s != t && nl[s] == nl[t] && (inl[t] % 2 == 0))
                        lose[s] = 1;
            for (int s = 0; s < NPORTS; s++) begin
                if (alive[s]) begin
                    line[s] = nl[s];
                    if (lose[s]) begin
                        alive[s] = 0;
                        r.blk[s] = 1'b1;
                    end
                end
            end
        end
        for (int s = 0; s < NPORTS; s++) begin
            if (alive[s]) begin
                r.vld[line[s]] = 1'b1;
                r.data[line[s]] = x[s];
            end
        end
        return r;
    endfunction

    task automatic check_outputs();
        slot_t e;
        string t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (out_vld !== e.vld) begin
            mismatched++;
            $display("FAIL %s out_vld actual %b expected %b", t, out_vld, e.vld);
        end
        compared++;
        if (blocked !== e.blk) begin
            mismatched++;
            $display("FAIL %s blocked actual %b expected %b", t, blocked, e.blk);
        end
        for (int i = 0; i < NPORTS; i++) begin
            if (e.vld[i]) begin
                compared++;
                if (out_data[i] !== e.data[i]) begin
                    mismatched++;
                    $display("FAIL %s out_data[%0d] actual %h expected %h", t, i, out_data[i], e.data[i]);
                end
                compared++;
                if (out_dst[i] !== PORT_W'(i)) begin
                    mismatched++;
                    $display("FAIL R3 out_dst[%0d] actual %0d expected %0d", i, out_dst[i], i);
                end
            end
        end
    endtask

    // One slot: check the outputs due now, then present new inputs.
    task automatic slot(input logic [NPORTS-1:0] v,
                        input logic [NPORTS-1:0][PORT_W-1:0] d,
                        input logic [NPORTS-1:0][DATA_W-1:0] x,
                        input string t);
        @(negedge clk);
        check_outputs();
        in_vld = v;
        in_dst = d;
        in_data = x;
        exp_q.push_back(model(v, d, x));
        tag_q.push_back(t);
    endtask

    function automatic logic [NPORTS-1:0][DATA_W-1:0] rnd_data();
        logic [NPORTS-1:0][DATA_W-1:0] x;
        for (int i = 0; i < NPORTS; i++) x[i] = DATA_W'($urandom);
        return x;
    endfunction

    initial begin
        #(8 * 200000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [NPORTS-1:0][PORT_W-1:0] d;
        logic [NPORTS-1:0][DATA_W-1:0] x;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: the three slots already in flight at reset release must be empty
        for (int k = 0; k < LAT; k++) begin
            exp_q.push_back('0);
            tag_q.push_back("R1");
        end

        // R2: every input to every destination, one cell at a time
        for (int s = 0; s < NPORTS; s++) begin
            for (int t = 0; t < NPORTS; t++) begin
                d = '0;
                d[s] = PORT_W'(t);
                x = '0;
                x[s] = DATA_W'((s << 8) | t | 16'hA000);
                slot(NPORTS'(1) << s, d, x, "R2");
            end
        end

        // R4: destination 101 from input 0 (lower, upper, lower)
        d = '0; d[0] = 3'b101; x = '0; x[0] = 16'h5101;
        slot(8'b0000_0001, d, x, "R4");

        // R7: invalid inputs carry junk destinations and data
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < NPORTS; i++) d[i] = PORT_W'($urandom);
            slot('0, d, rnd_data(), "R7");
        end
        d = '0; d[2] = 3'd6; d[5] = 3'd6;
        slot(8'b0000_0100, d, rnd_data(), "R7");

        // R8: identity and every cyclic shift, full load
        for (int c = 0; c < NPORTS; c++) begin
            for (int i = 0; i < NPORTS; i++) d[i] = PORT_W'(i + c);
            slot('1, d, rnd_data(), "R8");
        end

        // R5: inputs 0 and 4 share a rank-1 element and both want port 5
        d = '0; d[0] = 3'd5; d[4] = 3'd5;
        slot(8'b0001_0001, d, rnd_data(), "R5");
        // R5: hot spot, all inputs want one port, for each port
        for (int p = 0; p < NPORTS; p++) begin
            for (int i = 0; i < NPORTS; i++) d[i] = PORT_W'(p);
            slot('1, d, rnd_data(), "R5");
        end

        // R6: random full and partial loads
        for (int k = 0; k < 100; k++) begin
            for (int i = 0; i < NPORTS; i++) d[i] = PORT_W'($urandom);
            slot(NPORTS'($urandom), d, rnd_data(), "R6");
        end

        // R9: long back-to-back random stream
        for (int k = 0; k < 300; k++) begin
            for (int i = 0; i < NPORTS; i++) d[i] = PORT_W'($urandom);
            slot(NPORTS'($urandom | $urandom), d, rnd_data(), "R9");
        end

        // Drain the pipeline with idle slots
        for (int k = 0; k < LAT; k++) slot('0, '0, '0, "R9");
        @(negedge clk);
        check_outputs();

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule